// File: doc/BRIEF.md
# Four-Wire Serial Command Register Port

This block lets a host microcontroller reach a bank of internal registers over four wires: an active-high frame enable, a serial clock, a serial input line, and an open-drain serial output. All host pins are brought into the system clock domain through flop synchronisers. Bits are taken on the synchronised rising edge of the serial clock while the enable is high, and a frame is acted on when the enable falls.

A write frame is 16 bits, least significant bit first. The data byte comes first and the register address second. A read takes two frames. The first is a setup frame that names the register and carries a fixed read code. The next frame, whatever its length, is the read access: the selected register is shifted out on the open-drain output, least significant bit first. The block also holds an active-low interrupt line. A one-cycle request from the core sets it, and it stays asserted until the host reads or writes the status register.

Top module: `ser_cmd_regif`

## Requirements
- R1: A frame of 16 captured bits whose second byte is not 61h produces exactly one single-cycle register write. The first eight bits received, LSB first, form the data and the next eight form the address. The write is issued within a few clock cycles after the enable falls.
- R2: A frame in which fewer than 16 bits were clocked in is discarded, and no register write follows.
- R3: Clock edges after the 16th in a frame are ignored, and the frame keeps its first 16 bits.
- R4: A 16-bit frame whose second byte equals the read code 61h is a read setup. It writes nothing and arms a read of the register named by its first byte. Register address 61h can therefore never be written.
- R5: In the frame that follows a setup, bit 0 of the selected register is on the output before the first serial clock. Each later bit appears after a rising serial clock edge, LSB first, for eight bits.
- R6: The output pulls low only to send a 0 bit of an armed read frame while the enable is high. After the eighth bit, during writes and between frames, it is released and rests high.
- R7: The read access frame never causes a register write, whatever its length. It clears the armed state, so the frame after it is decoded normally.
- R8: The interrupt output is high after reset. It goes low the cycle after a one-cycle set request and stays low.
- R9: The interrupt output returns high after a read access frame of the status register (3Fh by default) ends, or after a write to that register. A set request in the same cycle wins.
- R10: During and right after reset, the write strobe is low, the output is released and the interrupt output is high.
- R11: Serial clock edges while the enable is low are ignored and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Frame enable from host, active high |
| host_sck | input | 1 | Serial clock from host |
| host_sdi | input | 1 | Serial data from host |
| sdo_pull_low | output | 1 | 1 pulls the open-drain output pin low; 0 releases it |
| irq_n | output | 1 | Interrupt to host, active low |
| irq_set | input | 1 | One-cycle interrupt request from the core |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | ADDR_W | Register write address |
| reg_wr_data | output | DATA_W | Register write data |
| reg_rd_addr | output | ADDR_W | Address of the register being read |
| reg_rd_data | input | DATA_W | Register contents for reg_rd_addr |

## Verification
The bench sends a short frame and an overlong frame. A design that counted badly would write a truncated or shifted byte, or take address bits from the tail of the frame. It also sends a setup frame and then a full 16-clock read frame. A design that did not tell setup and read frames apart would write to register 61h or to the read target. The bench returns to a plain write after each read, which catches a read state that never disarms. It clears the interrupt by writing the status register and, separately, by reading it, and it watches that the output never pulls low outside a read.

// File: rtl/regif_pkg.sv
package regif_pkg;

   // What a finished frame turns out to be
   typedef enum logic [1:0] {
      FK_NONE  = 2'd0,
      FK_WRITE = 2'd1,
      FK_SETUP = 2'd2,
      FK_READ  = 2'd3
   } frame_kind_e;

endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/regif_frame_rx.sv
module regif_frame_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_s,
   input  logic               sck_s,
   input  logic               sdi_s,
   output logic               frame_start,
   output logic               frame_end,
   output logic               bit_strobe,
   output logic               frame_full,
   output logic [FRAME_W-1:0] frame_bits
);

   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic             en_q, sck_q;
   logic [CNT_W-1:0] cnt;

   assign frame_start = en_s & ~en_q;
   assign frame_end   = ~en_s & en_q;
   assign bit_strobe  = en_s & sck_s & ~sck_q;
   assign frame_full  = (cnt == CNT_W'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         sck_q      <= 1'b0;
         cnt        <= '0;
         frame_bits <= '0;
      end else begin
         en_q  <= en_s;
         sck_q <= sck_s;
         if (frame_start) begin
            cnt <= '0;
         end else if (bit_strobe && !frame_full) begin
            frame_bits <= {sdi_s, frame_bits[FRAME_W-1:1]};
            cnt        <= cnt + 1'b1;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_W)); // R3
   AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_full && !frame_start) |=> $stable(frame_bits)); // R3

endmodule

// File: rtl/regif_read_tx.sv
module regif_read_tx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         advance,
   input  logic         clear,
   input  logic [W-1:0] value,
   output logic         tx_bit,
   output logic         tx_busy
);

   localparam int LEFT_W = $clog2(W + 1);

   logic [W-1:0]      sh;
   logic [LEFT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
      end else if (clear) begin
         left <= '0;
      end else if (load) begin
         sh   <= value;
         left <= LEFT_W'(W);
      end else if (advance && left != '0) begin
         sh   <= sh >> 1;
         left <= left - 1'b1;
      end
   end

   assign tx_bit  = sh[0];
   assign tx_busy = (left != '0);

   AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clear) |=> tx_busy); // R5
   AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !tx_busy); // R6

endmodule

// File: rtl/ser_cmd_regif.sv
module ser_cmd_regif #(
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int unsigned READ_CODE   = 'h61,
   parameter int unsigned STATUS_ADDR = 'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_en,
   input  logic              host_sck,
   input  logic              host_sdi,
   output logic              sdo_pull_low,
   output logic              irq_n,
   input  logic              irq_set,
   output logic              reg_wr_en,
   output logic [ADDR_W-1:0] reg_wr_addr,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic [ADDR_W-1:0] reg_rd_addr,
   input  logic [DATA_W-1:0] reg_rd_data
);
   import regif_pkg::*;

   localparam int               FRAME_W  = DATA_W + ADDR_W;
   localparam logic [ADDR_W-1:0] CODE_A  = ADDR_W'(READ_CODE);
   localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STATUS_ADDR);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < ADDR_W) begin : g_chk_width
      $error("setup frame needs DATA_W >= ADDR_W to carry an address");
   end

   logic [2:0]         pins_s;
   logic               en_s, sck_s, sdi_s;
   logic               frame_start, frame_end, bit_strobe, frame_full;
   logic [FRAME_W-1:0] frame_bits;
   logic [DATA_W-1:0]  data_f;
   logic [ADDR_W-1:0]  addr_f;
   logic               armed, irq_pend, tx_bit, tx_busy, irq_clr;
   frame_kind_e        kind;

   regif_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({host_en, host_sck, host_sdi}),
      .d_sync  (pins_s)
   );
   assign {en_s, sck_s, sdi_s} = pins_s;

   regif_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_s        (en_s),
      .sck_s       (sck_s),
      .sdi_s       (sdi_s),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .bit_strobe  (bit_strobe),
      .frame_full  (frame_full),
      .frame_bits  (frame_bits)
   );

   assign data_f = frame_bits[DATA_W-1:0];
   assign addr_f = frame_bits[FRAME_W-1:DATA_W];

   always_comb begin
      kind = FK_NONE;
      if (frame_end) begin
         if (armed)                kind = FK_READ;
         else if (frame_full)      kind = (addr_f == CODE_A) ? FK_SETUP : FK_WRITE;
      end
   end

   assign irq_clr = (kind == FK_READ  && reg_rd_addr == STAT_A) ||
                    (kind == FK_WRITE && addr_f == STAT_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         reg_rd_addr <= '0;
         reg_wr_en   <= 1'b0;
         reg_wr_addr <= '0;
         reg_wr_data <= '0;
         irq_pend    <= 1'b0;
      end else begin
         reg_wr_en <= (kind == FK_WRITE);
         if (kind == FK_WRITE) begin
            reg_wr_addr <= addr_f;
            reg_wr_data <= data_f;
         end
         if (kind == FK_SETUP) begin
            armed       <= 1'b1;
            reg_rd_addr <= data_f[ADDR_W-1:0];
         end else if (kind == FK_READ) begin
            armed <= 1'b0;
         end
         if (irq_set)      irq_pend <= 1'b1;
         else if (irq_clr) irq_pend <= 1'b0;
      end
   end

   regif_read_tx #(.W(DATA_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (frame_start & armed),
      .advance (bit_strobe),
      .clear   (frame_end),
      .value   (reg_rd_data),
      .tx_bit  (tx_bit),
      .tx_busy (tx_busy)
   );

   assign sdo_pull_low = armed & en_s & tx_busy & ~tx_bit;
   assign irq_n        = ~irq_pend;

   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en); // R1
   AST_NO_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (reg_wr_addr != CODE_A)); // R4
   AST_SDO_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_pull_low |-> (armed && en_s)); // R6
   AST_READ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FK_READ) |=> (!armed && !reg_wr_en)); // R7
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> !irq_n); // R8
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !irq_clr) |=> !irq_n); // R9
   AST_IDLE_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_s && !$past(en_s)) |=> !reg_wr_en); // R11

endmodule

// File: tb/ser_cmd_regif_tb.sv
module ser_cmd_regif_tb;

   localparam int CLK_PERIOD = 10;
   localparam int H          = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_en = 1'b0, host_sck = 1'b0, host_sdi = 1'b0;
   logic       irq_set = 1'b0;
   logic       sdo_pull_low, irq_n, reg_wr_en;
   logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;

   logic [7:0] reg_mem [256];
   logic [7:0] exp_mem [256];
   logic [15:0] exp_q [$];
   int checks = 0, errors = 0, stray = 0;
   bit reading = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ser_cmd_regif u_dut (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_sck(host_sck),
      .host_sdi(host_sdi), .sdo_pull_low(sdo_pull_low), .irq_n(irq_n),
      .irq_set(irq_set), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
      .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr),
      .reg_rd_data(reg_rd_data)
   );

   assign reg_rd_data = reg_mem[reg_rd_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Scoreboard monitor: every write strobe must match the oldest expected item
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sdo_pull_low && !reading) stray++;
         if (reg_wr_en) begin
            reg_mem[reg_wr_addr] = reg_wr_data;
            if (exp_q.size() == 0) begin
               check(1'b0, "R2/R4/R7 unexpected write", {reg_wr_addr, reg_wr_data}, 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check({reg_wr_addr, reg_wr_data} == e, "R1 write addr/data",
                     {reg_wr_addr, reg_wr_data}, e);
            end
         end
      end
   end

   task automatic send_frame(input int n, input logic [31:0] v);
      host_en = 1'b1;
      wait_n(H);
      for (int i = 0; i < n; i++) begin
         host_sdi = v[i];
         wait_n(H);
         host_sck = 1'b1;
         wait_n(H);
         host_sck = 1'b0;
      end
      wait_n(H);
      host_en = 1'b0;
      wait_n(3*H);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      exp_q.push_back({a, d});
      exp_mem[a] = d;
      send_frame(16, {16'h0, a, d});
   endtask

   task automatic do_setup(input logic [7:0] a);
      send_frame(16, {16'h0, 8'h61, a});
   endtask

   task automatic do_read(input logic [7:0] exp, input string req);
      logic [7:0] got;
      reading = 1'b1;
      host_en = 1'b1;
      wait_n(H);
      got[0] = ~sdo_pull_low;
      for (int i = 1; i < 8; i++) begin
         host_sck = 1'b1;
         wait_n(H);
         host_sck = 1'b0;
         wait_n(H);
         got[i] = ~sdo_pull_low;
      end
      host_sck = 1'b1;
      wait_n(H);
      host_sck = 1'b0;
      wait_n(H);
      check(sdo_pull_low == 1'b0, "R6 released after 8 bits", sdo_pull_low, 0);
      host_en = 1'b0;
      wait_n(3*H);
      reading = 1'b0;
      check(got == exp, req, got, exp);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         reg_mem[i] = 8'h00;
         exp_mem[i] = 8'h00;
      end
      wait_n(4);
      // R10: reset state
      check(reg_wr_en == 1'b0, "R10 strobe low in reset", reg_wr_en, 0);
      check(sdo_pull_low == 1'b0, "R10 output released in reset", sdo_pull_low, 0);
      check(irq_n == 1'b1, "R10 irq high in reset", irq_n, 1);
      rst_n = 1'b1;
      wait_n(4);
      check(irq_n == 1'b1, "R10 irq high after reset", irq_n, 1);

      // R1: plain writes
      do_write(8'h10, 8'hA5);
      do_write(8'h22, 8'h3C);
      check(exp_q.size() == 0, "R1 writes delivered", exp_q.size(), 0);

      // R2: short frame dropped
      send_frame(12, 32'h0000_0F77);
      check(exp_q.size() == 0, "R2 short frame no write", exp_q.size(), 0);

      // R3: extra bits ignored (bits 16..19 set)
      exp_q.push_back(16'h335A);
      exp_mem[8'h33] = 8'h5A;
      send_frame(20, 32'h000F_335A);
      check(exp_q.size() == 0, "R3 long frame keeps first 16 bits", exp_q.size(), 0);

      // R11: clocks with enable low
      host_sdi = 1'b1;
      for (int i = 0; i < 5; i++) begin
         host_sck = 1'b1; wait_n(H); host_sck = 1'b0; wait_n(H);
      end
      host_sdi = 1'b0;
      do_write(8'h44, 8'h81);
      check(exp_q.size() == 0, "R11 frame after idle clocks", exp_q.size(), 0);

      // R4, R5: setup then read
      do_setup(8'h10);
      check(exp_q.size() == 0, "R4 setup frame writes nothing", exp_q.size(), 0);
      do_read(exp_mem[8'h10], "R5 read 10h");
      do_setup(8'h22);
      do_read(exp_mem[8'h22], "R5 read 22h");
      do_setup(8'h33);
      do_read(exp_mem[8'h33], "R3 R5 read 33h");

      // R7: after a read the next frame is a normal write
      do_write(8'h10, 8'h0F);
      check(exp_q.size() == 0, "R7 write after read", exp_q.size(), 0);
      do_setup(8'h10);
      do_read(8'h0F, "R7 read back 10h");

      // R7: full 16-clock read frame writes nothing
      do_setup(8'h22);
      reading = 1'b1;
      send_frame(16, 32'h0000_6655);
      reading = 1'b0;
      check(reg_mem[8'h66] == 8'h00, "R7 read frame no write", reg_mem[8'h66], 0);
      do_write(8'h66, 8'h12);
      check(exp_q.size() == 0, "R7 decode resumes", exp_q.size(), 0);

      // R8, R9: interrupt set and clear by write
      irq_set = 1'b1; wait_n(1); irq_set = 1'b0;
      wait_n(2);
      check(irq_n == 1'b0, "R8 irq asserted", irq_n, 0);
      wait_n(50);
      check(irq_n == 1'b0, "R8 irq held", irq_n, 0);
      do_write(8'h3F, 8'h00);
      check(irq_n == 1'b1, "R9 irq cleared by status write", irq_n, 1);

      // R9: clear by status read; other reads do not clear
      irq_set = 1'b1; wait_n(1); irq_set = 1'b0;
      wait_n(2);
      do_setup(8'h44);
      do_read(exp_mem[8'h44], "R5 read 44h");
      check(irq_n == 1'b0, "R9 irq kept on other read", irq_n, 0);
      do_setup(8'h3F);
      do_read(exp_mem[8'h3F], "R5 read status");
      check(irq_n == 1'b1, "R9 irq cleared by status read", irq_n, 1);

      check(stray == 0, "R6 no pull outside reads", stray, 0);
      check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule